// File: doc/BRIEF.md
# Dual-Rail Serial Word Collector

This block gathers a sparse stream of single bits that arrive on two pulse lines. A pulse on one line carries a 0 and a pulse on the other carries a 1. Each accepted bit enters the first position of a collector shift register, and the bits already held move one place along. When a word is complete, the collector contents are copied in parallel into a release register and the collector is cleared. The release register is then sent out on a single line as a serial train: one bit slot per cycle, oldest bit first, with a pulse for a 1 and an empty slot for a 0.

The block has two modes, chosen by a parameter. In counting mode, a built-in counter starts the copy once exactly `WORD_LEN` bits have arrived (5 by default). In commanded mode, an external release command starts the copy and sends whatever bits are held. Commanded mode is normally built with a word length of 6. In that mode, a bit that arrives while the collector is full pushes the oldest held bit out on the output line, which gives a delayed copy of the input stream. Bits that arrive during a train go into the freed collector and do not disturb the train.

Top module: `serial_word_collector`

## Requirements
- R1: During reset and in the first cycle after it, out_valid, out_pulse and busy are all 0.
- R2: A pulse on in0_pulse alone stores a 0 and a pulse on in1_pulse alone stores a 1. The train sends the held bits oldest first, with out_pulse=1 for a stored 1 and out_pulse=0 for a stored 0.
- R3: In counting mode, out_valid rises in the second cycle after the cycle that carries the WORD_LEN-th bit pulse. It then stays high for exactly WORD_LEN cycles.
- R4: busy is high exactly while a train is being sent. out_valid is high for every slot of the train. out_pulse is never 1 while out_valid is 0.
- R5: A cycle with both input lines high is ignored: no bit is stored and no output appears because of it.
- R6: Bits accepted while busy is high are held as the start of the next word. The train in progress is not changed by them.
- R7: In counting mode, release_cmd has no effect.
- R8: In commanded mode, release_cmd with 1 to WORD_LEN bits held and busy low starts the train in the next cycle. The train carries exactly the held bits, oldest first.
- R9: In commanded mode, release_cmd is ignored when the collector is empty or busy is high.
- R10: In commanded mode, a bit accepted while the collector is full and busy is low pushes out the oldest held bit. In the next cycle out_valid is high for one cycle and out_pulse equals that bit. Afterwards the collector holds the newest WORD_LEN bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in0_pulse | input | 1 | One-cycle pulse carrying a 0 bit |
| in1_pulse | input | 1 | One-cycle pulse carrying a 1 bit |
| release_cmd | input | 1 | Starts the copy and the train in commanded mode |
| out_pulse | output | 1 | Serial output train, 1 = pulse |
| out_valid | output | 1 | Marks an output slot (train or pushed-out bit) |
| busy | output | 1 | A train is being sent |

## Verification
Two instances are swept: every 5-bit word in counting mode, and every word of every length from 1 to 6 in commanded mode. This catches reversed bit order, a swapped 0/1 line, off-by-one train lengths and a latency error of one cycle. Targeted cases cover a collision of both lines, which a faulty design would store as a bit and so shift every later word. They also cover bits arriving during a train, which a faulty design would drop or let leak into the release register. Release commands given while busy, with an empty collector, or in counting mode are applied as well; a faulty design would start a spurious train. The push-out of the oldest bit from a full collector is checked for both the emitted bit and the contents left behind.

// File: rtl/serial_word_collector.sv
module serial_word_collector #(
  parameter int WORD_LEN    = 5,
  parameter bit EXT_RELEASE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in0_pulse,
  input  logic in1_pulse,
  input  logic release_cmd,
  output logic out_pulse,
  output logic out_valid,
  output logic busy
);
  localparam int CW = $clog2(WORD_LEN + 1);

  logic [WORD_LEN-1:0] col, rel;
  logic [CW-1:0]       cnt, left;
  logic                dly_v, dly_b;

  logic bit_in, bval, full, xfer, push, shove;

  assign bit_in = in0_pulse ^ in1_pulse;
  assign bval   = in1_pulse & ~in0_pulse;
  assign full   = (cnt == CW'(WORD_LEN));
  assign busy   = (left != '0);

  generate
    if (EXT_RELEASE) begin : g_cmd
      assign xfer  = release_cmd & ~busy & (cnt != '0);
      assign shove = bit_in & full & ~busy & ~xfer;
    end else begin : g_cnt
      assign xfer  = full & ~busy;
      assign shove = 1'b0;
    end
  endgenerate

  assign push = bit_in & (xfer | ~full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col   <= '0;
      rel   <= '0;
      cnt   <= '0;
      left  <= '0;
      dly_v <= 1'b0;
      dly_b <= 1'b0;
    end else begin
      dly_v <= shove;
      if (shove) dly_b <= col[WORD_LEN-1];
      if (xfer) begin
        rel  <= col << (WORD_LEN - int'(cnt));
        left <= cnt;
        col  <= push ? {{(WORD_LEN-1){1'b0}}, bval} : '0;
        cnt  <= push ? CW'(1) : '0;
      end else begin
        if (busy) begin
          left <= left - 1'b1;
          rel  <= rel << 1;
        end
        if (push) begin
          col <= {col[WORD_LEN-2:0], bval};
          cnt <= cnt + 1'b1;
        end else if (shove) begin
          col <= {col[WORD_LEN-2:0], bval};
        end
      end
    end
  end

  assign out_valid = busy | dly_v;
  assign out_pulse = busy ? rel[WORD_LEN-1] : (dly_v & dly_b);
endmodule

// File: rtl/serial_word_collector_chk.sv
module serial_word_collector_chk #(
  parameter int WORD_LEN    = 5,
  parameter bit EXT_RELEASE = 1'b0,
  parameter int CW          = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in0_pulse,
  input logic          in1_pulse,
  input logic          release_cmd,
  input logic          out_pulse,
  input logic          out_valid,
  input logic          busy,
  input logic [CW-1:0] cnt
);
  logic trig;
  assign trig = !busy && (EXT_RELEASE ? (release_cmd && cnt != '0) : (cnt == CW'(WORD_LEN)));

  AST_PULSE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    out_pulse |-> out_valid); // R4
  AST_BUSY_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> out_valid); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(WORD_LEN)); // R3
  AST_COLLISION_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (in0_pulse && in1_pulse && !trig) |=> (cnt == $past(cnt))); // R5
  AST_FULL_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!EXT_RELEASE && !busy && cnt == CW'(WORD_LEN)) |=> busy); // R3
  AST_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!EXT_RELEASE && !busy && cnt != CW'(WORD_LEN)) |=> !busy); // R7
  AST_RELEASE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (EXT_RELEASE && release_cmd && !busy && cnt != '0) |=> busy); // R8
  AST_EMPTY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (EXT_RELEASE && !busy && cnt == '0) |=> !busy); // R9
  AST_FREED_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cnt <= CW'(1))); // R6
endmodule

bind serial_word_collector serial_word_collector_chk #(
  .WORD_LEN(WORD_LEN), .EXT_RELEASE(EXT_RELEASE), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in0_pulse(in0_pulse), .in1_pulse(in1_pulse),
  .release_cmd(release_cmd), .out_pulse(out_pulse), .out_valid(out_valid),
  .busy(busy), .cnt(cnt)
);

// File: tb/sim_serial_word_collector.sv
`timescale 1ns/1ps
module sim_serial_word_collector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] in0 = '0, in1 = '0, rel = '0;
  logic [1:0] op, ov, bz;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serial_word_collector #(.WORD_LEN(5), .EXT_RELEASE(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .in0_pulse(in0[0]), .in1_pulse(in1[0]),
    .release_cmd(rel[0]), .out_pulse(op[0]), .out_valid(ov[0]), .busy(bz[0]));

  serial_word_collector #(.WORD_LEN(6), .EXT_RELEASE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .in0_pulse(in0[1]), .in1_pulse(in1[1]),
    .release_cmd(rel[1]), .out_pulse(op[1]), .out_valid(ov[1]), .busy(bz[1]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // b: 0 -> zero line, 1 -> one line, 2 -> both lines
  task automatic pulse(input int d, input int b);
    @(negedge clk);
    in0[d] = (b != 1);
    in1[d] = (b != 0);
    @(negedge clk);
    in0[d] = 1'b0;
    in1[d] = 1'b0;
  endtask

  task automatic release_pulse(input int d);
    @(negedge clk);
    rel[d] = 1'b1;
    @(negedge clk);
    rel[d] = 1'b0;
  endtask

  task automatic send(input int d, input int word, input int k);
    for (int i = k - 1; i >= 0; i--) pulse(d, (word >> i) & 1);
  endtask

  task automatic train(input int d, input int word, input int k, input string req);
    for (int i = k - 1; i >= 0; i--) begin
      chk_eq({req, " valid"}, ov[d], 1);
      chk_eq({req, " busy"}, bz[d], 1);
      chk_eq({req, " bit"}, op[d], (word >> i) & 1);
      @(negedge clk);
    end
    chk_eq({req, " end"}, ov[d], 0);
    chk_eq({req, " busy end"}, bz[d], 0);
  endtask

  initial begin
    int guard = 0;
    while (!done && guard < 150000) begin
      @(posedge clk);
      guard++;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk_eq("R1 valid", ov[d], 0);
      chk_eq("R1 pulse", op[d], 0);
      chk_eq("R1 busy", bz[d], 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 2; d++) chk_eq("R1 after reset", ov[d] | bz[d] | op[d], 0);

    // R2 R3: every 5-bit word, counting mode
    for (int w = 0; w < 32; w++) begin
      send(0, w, 5);
      chk_eq("R3 latency", ov[0], 0);
      @(negedge clk);
      train(0, w, 5, "R2 R3 counting word");
    end

    // R5: collision mid-word
    send(0, 2, 2);
    pulse(0, 2);
    chk_eq("R5 no output", ov[0], 0);
    send(0, 5, 3);
    chk_eq("R5 latency", ov[0], 0);
    @(negedge clk);
    train(0, 5'b10101, 5, "R5 collision skipped");

    // R7: release in counting mode
    send(0, 3, 2);
    release_pulse(0);
    chk_eq("R7 no train", ov[0], 0);
    @(negedge clk);
    chk_eq("R7 no train later", ov[0], 0);
    send(0, 1, 3);
    @(negedge clk);
    train(0, 5'b11001, 5, "R7 word intact");

    // R6: next word arrives during the train
    send(0, 5'b10011, 5);
    @(negedge clk);
    for (int i = 4; i >= 0; i--) begin
      chk_eq("R6 train valid", ov[0], 1);
      chk_eq("R6 train bit", op[0], (5'b10011 >> i) & 1);
      in0[0] = !((5'b01110 >> i) & 1);
      in1[0] = (5'b01110 >> i) & 1;
      @(negedge clk);
    end
    in0[0] = 1'b0;
    in1[0] = 1'b0;
    chk_eq("R6 gap", ov[0], 0);
    @(negedge clk);
    train(0, 5'b01110, 5, "R6 held word");

    // R2 R8: every word of length 1..6, commanded mode
    for (int k = 1; k <= 6; k++)
      for (int w = 0; w < (1 << k); w++) begin
        send(1, w, k);
        chk_eq("R8 idle before release", ov[1], 0);
        release_pulse(1);
        train(1, w, k, "R2 R8 commanded word");
      end

    // R9: empty release, release while busy
    release_pulse(1);
    chk_eq("R9 empty release", ov[1], 0);
    @(negedge clk);
    chk_eq("R9 empty release later", ov[1], 0);
    send(1, 2'b10, 2);
    release_pulse(1);
    chk_eq("R9 slot0", op[1], 1);
    in1[1] = 1'b1;
    @(negedge clk);
    in1[1] = 1'b0;
    chk_eq("R9 slot1", op[1], 0);
    rel[1] = 1'b1;
    @(negedge clk);
    rel[1] = 1'b0;
    chk_eq("R9 busy release ignored", ov[1], 0);
    @(negedge clk);
    chk_eq("R9 busy release ignored later", ov[1], 0);
    release_pulse(1);
    train(1, 1, 1, "R6 R9 held bit");

    // R10: push-out from a full collector
    send(1, 6'b101100, 6);
    pulse(1, 0);
    chk_eq("R10 pushed valid", ov[1], 1);
    chk_eq("R10 pushed bit", op[1], 1);
    chk_eq("R10 not busy", bz[1], 0);
    @(negedge clk);
    chk_eq("R10 single slot", ov[1], 0);
    pulse(1, 1);
    chk_eq("R10 pushed bit 2", op[1], 0);
    @(negedge clk);
    release_pulse(1);
    train(1, 6'b110001, 6, "R10 remaining");

    // R5 in commanded mode
    pulse(1, 1);
    pulse(1, 2);
    chk_eq("R5 commanded no output", ov[1], 0);
    release_pulse(1);
    train(1, 1, 1, "R5 commanded length");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule